// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

This block gathers interrupt requests from a small set of sources and presents one interrupt line to a processor. Each source has its own request line, and a pulse on that line sets a sticky bit in a request register. The processor owns a mask register that can hide any source. A latched request stays in the request register while its source is hidden, and it reappears once the source is unmasked. A fixed-priority encoder picks the lowest-numbered visible request. Its index forms the low bits of an interrupt vector. The upper bits of the vector come from a base register that software can write.

Two flip-flops gate the interrupt line and the vector:

- **Status flip-flop.** It records that at least one visible request is pending.
- **Enable flip-flop.** Software sets it. An accepted acknowledge clears it, so the controller stays quiet while a handler runs.

When the processor acknowledges while both flip-flops are set, the block raises a valid flag and drives the vector. At all other times the vector output reads zero. The processor clears a serviced request with a write-one-to-clear strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request and mask registers are all zero, with every source unmasked. The status and enable flip-flops are clear. The base register holds its reset value, 6'h30 by default. `cpu_irq`, `vec_valid` and `vec_out` are all 0.
- R2: If `irq_in[i]` is 1 during any clock cycle, request bit i is set at that clock edge. The bit stays set until software clears it. A one-cycle pulse is therefore enough to keep `cpu_irq` asserted two cycles later and afterwards, provided the source is unmasked and the enable flip-flop is set.
- R3: Mask bit i set to 1 removes source i from the status and priority logic without erasing its latched request. After the mask bit is written to 0, the request is visible again and asserts `cpu_irq` two cycles after the mask write.
- R4: Among the visible requests, the lowest index has the highest priority. Bits [1:0] of `vec_out` carry that index in binary.
- R5: The upper bits of `vec_out` (bits [7:2] by default) equal the base register. The base register is loaded from `base_wdata` in a cycle with `base_we` high.
- R6: The status flip-flop is set one cycle after any visible request is pending and clears one cycle after none remain. `cpu_irq` is 1 exactly when the status and enable flip-flops are both set.
- R7: `vec_valid` is 1 only when `intack`, the status flip-flop and the enable flip-flop are all 1. While `vec_valid` is 0, `vec_out` is zero.
- R8: A cycle with `vec_valid` high clears the enable flip-flop, so `cpu_irq` falls in the next cycle. A cycle with `ien_set` high and no accepted acknowledge sets the enable flip-flop again.
- R9: A cycle with `clr_we` high clears every request bit whose `clr_wdata` bit is 1. If `irq_in` of that same bit is also 1 in that cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Per-source request lines |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | N_SRC | Mask value, 1 disables a source |
| clr_we | input | 1 | Request clear strobe |
| clr_wdata | input | N_SRC | Write-one-to-clear request bits |
| ien_set | input | 1 | Sets the enable flip-flop |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | VEC_W-2 | New vector base (width VEC_W minus index width) |
| intack | input | 1 | Interrupt acknowledge from the processor |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector is being driven |
| vec_out | output | VEC_W | Interrupt vector, zero when not valid |

## Verification
The bench sweeps every combination of request pattern and mask and checks the interrupt line and the vector for each one. This catches an encoder that favours the highest index, and a mask applied after the encoder instead of before it, which would let a hidden source win. It also checks that the interrupt line falls after an accepted acknowledge. A design that missed this would keep interrupting during the handler. Directed cases cover three more faults:

- A mask that erases the request, so the source never reappears after unmasking.
- A clear that beats a request arriving in the same cycle, so an event is lost.
- A base register that does not reach the vector's upper bits.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_SRC_DEF = 4;
  localparam int unsigned VEC_W_DEF   = 8;
  localparam int unsigned BASE_RST_DEF = 'h30;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pic_req_bank.sv
module pic_req_bank #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_wdata,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  output logic [N_SRC-1:0] req_q,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] req_d;
  logic [N_SRC-1:0] mask_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // a fresh request in the clear cycle keeps the bit set
    always_comb begin
      req_d[i]  = irq_in[i] | (req_q[i] & ~(clr_we & clr_wdata[i]));
      mask_d[i] = mask_we ? mask_wdata[i] : mask_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        req_q[i] <= req_d[i];
        if (mask_we) mask_q[i] <= mask_d[i];
      end
    end

    assign pend[i] = req_q[i] & ~mask_q[i];
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N_SRC-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N_SRC:0]   seen;
  logic [N_SRC-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign grant[i]  = pend[i] & ~seen[i];
    assign seen[i+1] = seen[i] | pend[i];
  end

  assign any = seen[N_SRC];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic_ack_gate.sv
module pic_ack_gate #(
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned BASE_W   = 6,
  parameter int unsigned BASE_RST = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [IDX_W-1:0]  idx,
  input  logic              intack,
  input  logic              ien_set,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  output logic              cpu_irq,
  output logic              vec_valid,
  output logic [BASE_W+IDX_W-1:0] vec_out,
  output logic              ien_q
);
  logic              ist_q, ist_d;
  logic [IDX_W-1:0]  win_q, win_d;
  logic              ien_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              take;

  assign take = intack & ist_q & ien_q;

  always_comb begin
    ist_d  = any;
    win_d  = idx;
    base_d = base_we ? base_wdata : base_q;
    if (take)         ien_d = 1'b0;
    else if (ien_set) ien_d = 1'b1;
    else              ien_d = ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q  <= 1'b0;
      win_q  <= '0;
      ien_q  <= 1'b0;
      base_q <= BASE_W'(BASE_RST);
    end else begin
      ist_q <= ist_d;
      win_q <= win_d;
      ien_q <= ien_d;
      if (base_we) base_q <= base_d;
    end
  end

  assign cpu_irq   = ist_q & ien_q;
  assign vec_valid = take;
  assign vec_out   = take ? {base_q, win_q} : '0;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC    = NUM_SRC_DEF,
  parameter int unsigned VEC_W    = VEC_W_DEF,
  parameter int unsigned BASE_RST = BASE_RST_DEF,
  localparam int unsigned IDX_W   = idx_width(N_SRC),
  localparam int unsigned BASE_W  = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              mask_we,
  input  logic [N_SRC-1:0]  mask_wdata,
  input  logic              clr_we,
  input  logic [N_SRC-1:0]  clr_wdata,
  input  logic              ien_set,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic              intack,
  output logic              cpu_irq,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out
);
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] pend;
  logic             any;
  logic [IDX_W-1:0] idx;
  logic             ien_q;

  pic_req_bank #(.N_SRC(N_SRC)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .clr_we     (clr_we),
    .clr_wdata  (clr_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .req_q      (req_q),
    .mask_q     (mask_q),
    .pend       (pend)
  );

  pic_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_enc (
    .pend (pend),
    .any  (any),
    .idx  (idx)
  );

  pic_ack_gate #(.IDX_W(IDX_W), .BASE_W(BASE_W), .BASE_RST(BASE_RST)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .any        (any),
    .idx        (idx),
    .intack     (intack),
    .ien_set    (ien_set),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .cpu_irq    (cpu_irq),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out),
    .ien_q      (ien_q)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_in,
  input logic             clr_we,
  input logic             intack,
  input logic             cpu_irq,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_out,
  input logic [N_SRC-1:0] req_q,
  input logic [N_SRC-1:0] mask_q,
  input logic             ien_q
);
  AST_QUIET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_out == '0)); // R7

  AST_VALID_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (intack && cpu_irq)); // R7

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !cpu_irq); // R8

  AST_PEND_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(req_q & ~mask_q)) && ien_q && !vec_valid) |=> cpu_irq); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_q & ~mask_q)) |=> !cpu_irq); // R6

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (($past(req_q) & ~req_q) == '0)); // R2

  AST_NEW_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_in) & ~req_q) == '0)); // R9
endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .clr_we    (clr_we),
  .intack    (intack),
  .cpu_irq   (cpu_irq),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .req_q     (req_q),
  .mask_q    (mask_q),
  .ien_q     (ien_q)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/100ps
module prio_irq_ctrl_test;
  localparam int N = 4;
  localparam int VW = 8;
  localparam int BW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          mask_we = 1'b0;
  logic [N-1:0]  mask_wdata = '0;
  logic          clr_we = 1'b0;
  logic [N-1:0]  clr_wdata = '0;
  logic          ien_set = 1'b0;
  logic          base_we = 1'b0;
  logic [BW-1:0] base_wdata = '0;
  logic          intack = 1'b0;
  logic          cpu_irq;
  logic          vec_valid;
  logic [VW-1:0] vec_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [BW-1:0] base_exp = 6'h30;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
    .ien_set(ien_set), .base_we(base_we), .base_wdata(base_wdata),
    .intack(intack), .cpu_irq(cpu_irq), .vec_valid(vec_valid),
    .vec_out(vec_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    irq_in = '0; mask_we = 0; clr_we = 0; clr_wdata = '0;
    ien_set = 0; base_we = 0; intack = 0;
  endtask

  // clear all requests, load mask, arm enable
  task automatic prep(input logic [N-1:0] m);
    idle_inputs();
    clr_we = 1; clr_wdata = '1; mask_we = 1; mask_wdata = m; ien_set = 1;
    tick();
    idle_inputs();
  endtask

  function automatic int low_idx(input logic [N-1:0] p);
    for (int i = N - 1; i >= 0; i--) if (p[i]) low_idx = i;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", cpu_irq, 0);
    chk("R1 valid in reset", vec_valid, 0);
    chk("R1 vec in reset", vec_out, 0);
    rst_n = 1'b1;
    tick();
    intack = 1; #1;
    chk("R1 irq after reset", cpu_irq, 0);
    chk("R1 valid after reset", vec_valid, 0);
    chk("R1 vec after reset", vec_out, 0);
    idle_inputs();
    tick();

    // R4 R6 R7 R8 sweep of all requests against all masks
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [N-1:0] vis;
        vis = N'(p) & ~N'(m);
        prep(N'(m));
        irq_in = N'(p);
        tick();
        irq_in = '0;
        tick();
        chk("R6 irq level", cpu_irq, (vis != 0));
        chk("R7 no vec without ack", {vec_valid, vec_out}, 0);
        intack = 1; #1;
        chk("R7 valid on ack", vec_valid, (vis != 0));
        chk("R4 R5 vector", vec_out, (vis != 0) ? {base_exp, 2'(low_idx(vis))} : 8'h0);
        tick();
        intack = 0; #1;
        chk("R8 irq drops after ack", cpu_irq, 0);
        chk("R7 no vec after ack", vec_valid, 0);
      end
    end

    // R8 enable rewrite re-raises the line for a still pending request
    prep('0);
    irq_in = 4'b1000; tick(); irq_in = '0; tick();
    intack = 1; tick(); intack = 0;
    chk("R8 irq off in handler", cpu_irq, 0);
    ien_set = 1; tick(); ien_set = 0;
    chk("R8 irq back after set", cpu_irq, 1);

    // R2 a single pulse is held for many cycles
    prep('0);
    irq_in = 4'b0100; tick(); irq_in = '0;
    repeat (6) tick();
    chk("R2 latched request", cpu_irq, 1);

    // R3 masked request is kept and returns on unmask
    prep(4'b0010);
    irq_in = 4'b0010; tick(); irq_in = '0;
    repeat (3) tick();
    chk("R3 masked hides", cpu_irq, 0);
    mask_we = 1; mask_wdata = '0; tick(); mask_we = 0;
    tick();
    chk("R3 unmask returns", cpu_irq, 1);
    intack = 1; #1;
    chk("R3 unmasked vector", vec_out, {base_exp, 2'd1});
    tick(); intack = 0;

    // R9 clear versus same-cycle request
    prep('0);
    irq_in = 4'b0100; tick();
    clr_we = 1; clr_wdata = 4'b0100; tick();
    idle_inputs(); tick();
    chk("R9 new request beats clear", cpu_irq, 1);
    clr_we = 1; clr_wdata = 4'b0100; tick();
    idle_inputs(); tick();
    chk("R9 clear removes request", cpu_irq, 0);
    clr_we = 1; clr_wdata = 4'b0001;
    irq_in = 4'b1000; tick();
    idle_inputs(); tick();
    chk("R9 clear leaves other bit", cpu_irq, 1);

    // R5 base register write
    base_we = 1; base_wdata = 6'h2A; tick(); base_we = 0;
    base_exp = 6'h2A;
    for (int p = 1; p < 16; p++) begin
      prep('0);
      irq_in = N'(p); tick(); irq_in = '0; tick();
      intack = 1; #1;
      chk("R5 base in vector", vec_out, {base_exp, 2'(low_idx(N'(p)))});
      tick(); intack = 0;
    end

    finish_run();
  end
endmodule